// File: doc/BRIEF.md
# ADC Auto-Trigger Selector

This block decides when the next analog-to-digital conversion begins. A 3-bit select code picks one candidate flag: either the converter's own conversion-complete flag (free-running operation) or one of six event flags from neighbouring peripherals. The block watches the chosen flag and turns its rising edge into a single-cycle start strobe for the conversion sequencer. The strobe is produced only when automatic triggering is enabled, the converter is enabled and the sequencer is not busy.

Edge detection follows the multiplexer. As a result, moving the select from a low source to a high source counts as a rising edge. The single exception is a move into free-running mode, which never fires on entry. All flag inputs are taken as already synchronous to the block clock. Reset is synchronous and active high.

Top module: `adc_trig_sel`

## Requirements
- R1: Select codes map to flags as follows. 0 is `conv_done`; 1 to 6 are `src_flags[0]` to `src_flags[5]` (1 comparator, 2 external interrupt 0, 3 timer compare A, 4 timer overflow, 5 timer compare B, 6 pin change). A rising edge of the selected flag triggers a start.
- R2: The selected flag is low in one cycle and high in the cycle after that edge. `start` is then high for the cycle that follows that edge.
- R3: Changing `src_sel` from a source whose flag is low to a source whose flag is high counts as a rising edge and produces a start.
- R4: Changing `src_sel` to 0 produces no start, even if `conv_done` is already high.
- R5: While `src_sel` stays 0, each later rising edge of `conv_done` produces a start.
- R6: While `auto_en` is low, no start is produced, whatever the select value or flag activity.
- R7: While `conv_en` is low, no start is produced.
- R8: A trigger that arrives while `busy` is high is dropped. No start follows when `busy` later falls.
- R9: Select code 7 never produces a start.
- R10: `start` is low during reset and never stays high for two cycles in a row. The stored previous flag level resets to 0, so a flag that is high when reset is released gives one start.
- R11: Edges on flags that are not selected have no effect on `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Converter enable |
| auto_en | input | 1 | Automatic trigger enable |
| src_sel | input | 3 | Trigger source select code |
| src_flags | input | 6 | Event flags for select codes 1 to 6 |
| conv_done | input | 1 | Conversion-complete flag (free-running source) |
| busy | input | 1 | Sequencer busy; triggers are dropped while high |
| start | output | 1 | One-cycle conversion start strobe |

## Verification
The bench moves into free-running mode while the completion flag is already high. A design that detects edges after the multiplexer without the entry exemption would start a spurious conversion there. It switches the select onto a source whose flag is already high, which a design detecting edges before the multiplexer would miss. It raises a flag while busy and then lowers busy, which exposes any design that queues the trigger. It also holds a flag high across reset to show the previous-level register clearing to zero, and it toggles flags under code 7 and on unselected sources, where any start means a decode fault.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;
  typedef enum logic [2:0] {
    SEL_FREE = 3'd0,
    SEL_ACMP = 3'd1,
    SEL_EXT0 = 3'd2,
    SEL_CMPA = 3'd3,
    SEL_OVF  = 3'd4,
    SEL_CMPB = 3'd5,
    SEL_PCHG = 3'd6,
    SEL_RSVD = 3'd7
  } trig_sel_e;

  // rising level: low last cycle, high now
  function automatic logic is_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // entry into free-running: select is zero now and was nonzero last cycle
  function automatic logic is_free_entry(input logic [2:0] sel, input logic [2:0] sel_prev);
    return (sel == SEL_FREE) && (sel_prev != SEL_FREE);
  endfunction
endpackage

// File: rtl/trig_src_mux.sv
`timescale 1ns/1ps
module trig_src_mux #(
  parameter int SEL_W = 3,
  parameter int NSRC  = 6
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  flags,
  input  logic             done_flag,
  output logic             picked
);
  localparam int NCODE = 1 << SEL_W;

  logic [NCODE-1:0] cand;

  assign cand[0] = done_flag;
  for (genvar i = 1; i < NCODE; i++) begin : g_cand
    if (i <= NSRC) begin : g_src
      assign cand[i] = flags[i-1];
    end else begin : g_rsvd
      assign cand[i] = 1'b0;
    end
  end

  assign picked = cand[sel];
endmodule

// File: rtl/trig_edge_det.sv
`timescale 1ns/1ps
module trig_edge_det
  import adc_trig_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             level,
  output logic             edge_hit,
  output logic             fr_entry
);
  logic             prev_lvl;
  logic [SEL_W-1:0] prev_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      prev_sel <= '0;
    end else begin
      prev_lvl <= level;
      prev_sel <= sel;
    end
  end

  assign edge_hit = is_rise(level, prev_lvl);
  assign fr_entry = is_free_entry(sel, prev_sel);
endmodule

// File: rtl/trig_start_gate.sv
`timescale 1ns/1ps
module trig_start_gate (
  input  logic clk,
  input  logic rst,
  input  logic edge_hit,
  input  logic fr_entry,
  input  logic auto_en,
  input  logic conv_en,
  input  logic busy,
  output logic start
);
  logic fire;

  assign fire = edge_hit & ~fr_entry & auto_en & conv_en & ~busy;

  always_ff @(posedge clk) begin
    if (rst) start <= 1'b0;
    else     start <= fire;
  end
endmodule

// File: rtl/adc_trig_sel.sv
`timescale 1ns/1ps
module adc_trig_sel #(
  parameter int SEL_W = 3,
  parameter int NSRC  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_en,
  input  logic             auto_en,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [NSRC-1:0]  src_flags,
  input  logic             conv_done,
  input  logic             busy,
  output logic             start
);
  logic picked;
  logic edge_hit;
  logic fr_entry;

  trig_src_mux #(.SEL_W(SEL_W), .NSRC(NSRC)) u_mux (
    .sel       (src_sel),
    .flags     (src_flags),
    .done_flag (conv_done),
    .picked    (picked)
  );

  trig_edge_det #(.SEL_W(SEL_W)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .sel      (src_sel),
    .level    (picked),
    .edge_hit (edge_hit),
    .fr_entry (fr_entry)
  );

  trig_start_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .edge_hit (edge_hit),
    .fr_entry (fr_entry),
    .auto_en  (auto_en),
    .conv_en  (conv_en),
    .busy     (busy),
    .start    (start)
  );
endmodule

// File: rtl/adc_trig_sel_chk.sv
`timescale 1ns/1ps
module adc_trig_sel_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_en,
  input logic             auto_en,
  input logic             busy,
  input logic [SEL_W-1:0] src_sel,
  input logic             edge_hit,
  input logic             fr_entry,
  input logic             start
);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  assert_fr_entry_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    fr_entry |=> !start);

  assert_edge_cause_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(edge_hit));

  assert_auto_gate_R6: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(auto_en));

  assert_conv_gate_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(conv_en));

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
    start |-> !$past(busy));

  assert_rsvd_silent_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> ($past(src_sel) != SEL_W'(7)));
endmodule

bind adc_trig_sel adc_trig_sel_chk #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .conv_en  (conv_en),
  .auto_en  (auto_en),
  .busy     (busy),
  .src_sel  (src_sel),
  .edge_hit (edge_hit),
  .fr_entry (fr_entry),
  .start    (start)
);

// File: tb/adc_trig_sel_test.sv
`timescale 1ns/1ps
module adc_trig_sel_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_en = 1'b0;
  logic       auto_en = 1'b0;
  logic [2:0] src_sel = 3'd1;
  logic [5:0] src_flags = '0;
  logic       conv_done = 1'b0;
  logic       busy = 1'b0;
  logic       start;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_trig_sel uut (
    .clk(clk), .rst(rst), .conv_en(conv_en), .auto_en(auto_en),
    .src_sel(src_sel), .src_flags(src_flags), .conv_done(conv_done),
    .busy(busy), .start(start)
  );

  // {req[17:14], auto_en, conv_en, busy, sel[10:8], flags[7:2], done, exp_start}
  localparam int NV = 30;
  localparam logic [17:0] VEC [NV] = '{
    {4'd10, 1'b1,1'b1,1'b0, 3'd1, 6'b000000, 1'b0, 1'b0}, // R10 idle
    {4'd2,  1'b1,1'b1,1'b0, 3'd1, 6'b000001, 1'b0, 1'b1}, // R2 comparator rises
    {4'd10, 1'b1,1'b1,1'b0, 3'd1, 6'b000001, 1'b0, 1'b0}, // R10 held high
    {4'd2,  1'b1,1'b1,1'b0, 3'd1, 6'b000000, 1'b0, 1'b0}, // R2 fall
    {4'd11, 1'b1,1'b1,1'b0, 3'd2, 6'b000100, 1'b0, 1'b0}, // R11 unselected rise
    {4'd3,  1'b1,1'b1,1'b0, 3'd3, 6'b000100, 1'b0, 1'b1}, // R3 switch onto high
    {4'd3,  1'b1,1'b1,1'b0, 3'd3, 6'b000000, 1'b0, 1'b0}, // R3
    {4'd1,  1'b1,1'b1,1'b0, 3'd4, 6'b001000, 1'b0, 1'b1}, // R1 overflow code
    {4'd1,  1'b1,1'b1,1'b0, 3'd4, 6'b000000, 1'b0, 1'b0}, // R1
    {4'd1,  1'b1,1'b1,1'b0, 3'd5, 6'b010000, 1'b0, 1'b1}, // R1 compare B code
    {4'd1,  1'b1,1'b1,1'b0, 3'd5, 6'b000000, 1'b0, 1'b0}, // R1
    {4'd1,  1'b1,1'b1,1'b0, 3'd6, 6'b100000, 1'b0, 1'b1}, // R1 pin change code
    {4'd11, 1'b1,1'b1,1'b0, 3'd6, 6'b000000, 1'b1, 1'b0}, // R11 done while not selected
    {4'd4,  1'b1,1'b1,1'b0, 3'd0, 6'b000000, 1'b1, 1'b0}, // R4 enter free-run, done high
    {4'd5,  1'b1,1'b1,1'b0, 3'd0, 6'b000000, 1'b0, 1'b0}, // R5
    {4'd5,  1'b1,1'b1,1'b0, 3'd0, 6'b000000, 1'b1, 1'b1}, // R5 done rises
    {4'd5,  1'b1,1'b1,1'b0, 3'd0, 6'b000000, 1'b0, 1'b0}, // R5
    {4'd5,  1'b1,1'b1,1'b0, 3'd0, 6'b000000, 1'b1, 1'b1}, // R5 again
    {4'd9,  1'b1,1'b1,1'b0, 3'd7, 6'b111111, 1'b1, 1'b0}, // R9 reserved
    {4'd9,  1'b1,1'b1,1'b0, 3'd7, 6'b000000, 1'b0, 1'b0}, // R9
    {4'd9,  1'b1,1'b1,1'b0, 3'd7, 6'b111111, 1'b1, 1'b0}, // R9 flags rise
    {4'd6,  1'b0,1'b1,1'b0, 3'd1, 6'b111111, 1'b0, 1'b0}, // R6 switch with auto off
    {4'd6,  1'b0,1'b1,1'b0, 3'd1, 6'b000000, 1'b0, 1'b0}, // R6
    {4'd6,  1'b0,1'b1,1'b0, 3'd1, 6'b000001, 1'b0, 1'b0}, // R6 rise with auto off
    {4'd7,  1'b1,1'b0,1'b0, 3'd1, 6'b000000, 1'b0, 1'b0}, // R7
    {4'd7,  1'b1,1'b0,1'b0, 3'd1, 6'b000001, 1'b0, 1'b0}, // R7 rise with conv off
    {4'd8,  1'b1,1'b1,1'b1, 3'd1, 6'b000000, 1'b0, 1'b0}, // R8
    {4'd8,  1'b1,1'b1,1'b1, 3'd1, 6'b000001, 1'b0, 1'b0}, // R8 rise while busy
    {4'd8,  1'b1,1'b1,1'b0, 3'd1, 6'b000001, 1'b0, 1'b0}, // R8 busy falls, no queue
    {4'd8,  1'b1,1'b1,1'b0, 3'd1, 6'b000000, 1'b0, 1'b0}  // R8
  };

  task automatic check(input string req, input logic exp);
    total++;
    if (start !== exp) begin
      bad++;
      $display("FAIL %s: start=%0b expected=%0b at %0t", req, start, exp, $time);
    end
  endtask

  initial begin
    #100000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      auto_en   = VEC[i][13];
      conv_en   = VEC[i][12];
      busy      = VEC[i][11];
      src_sel   = VEC[i][10:8];
      src_flags = VEC[i][7:2];
      conv_done = VEC[i][1];
      @(negedge clk);
      total++;
      if (start !== VEC[i][0]) begin
        bad++;
        $display("FAIL R%0d vec %0d: start=%0b expected=%0b", VEC[i][17:14], i, start, VEC[i][0]);
      end
    end
    // directed: flag held high across reset (R10)
    src_flags = 6'b000001;
    @(negedge clk);
    check("R2 directed rise", 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R10 start low in reset", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 prev level cleared", 1'b1);
    @(negedge clk);
    check("R10 one-cycle strobe", 1'b0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule